// File: doc/BRIEF.md
# Flash Write-Protection Command Gate

This block is a synchronous front end that sits ahead of a NOR flash array model. It samples the asynchronous strobes of the flash bus: chip select, read enable and write enable. It also samples the address and data buses, a boot-lock pin, a device clear pin and a supply-good flag. From these it works out when a real bus write cycle took place. A strobe has to stay low for a minimum number of clocks before the write counts, so short noise pulses are dropped. Writes are refused while the supply is low or the strobe combination is not a write.

Accepted write cycles feed a command tracker. The tracker recognises the three-write program unlock and the six-write erase unlock. It issues a single-cycle program or erase request only when every protection check passes. One such check is the pin-controlled lock of an 8K-word boot block, placed at the bottom or the top of the address space by a parameter. There is no way to switch off the software unlock requirement.

After each request the block reports busy for a fixed number of clocks. Holding the clear pin low long enough aborts a running operation. It also drops any partly entered command. After a long clear, read data is reported valid only after a recovery delay.

Top module: `flash_guard`

## Requirements
- R1: A write cycle is taken only while chip_sel_n is low, wr_en_n is low and rd_en_n is high. Read enable low, chip select high or write enable high each block the write. A blocked write does not use up a step of a pending command.
- R2: A write strobe counts only after it has stayed active for GLITCH_CYC consecutive clocks, once per strobe. A strobe that is active for GLITCH_CYC-1 clocks or fewer is dropped.
- R3: While pwr_ok is low no write cycle is accepted. A pending command keeps waiting for its next valid write.
- R4: Program is the write sequence (word 0x05555, data byte 0xAA), then (0x02AAA, 0x55), then (0x05555, 0xA0), then one write that carries the target. That last write gives a one-cycle prog_req with req_addr and req_data equal to the target address and data. Only the low data byte is compared.
- R5: Erase starts with 0xAA, 0x55, 0x80 written to 0x05555, 0x02AAA and 0x05555, followed by 0xAA to 0x05555 and 0x55 to 0x02AAA. The final write is one of two. Data byte 0x30 to any address gives a one-cycle erase_req with erase_chip=0 and req_addr set to that address. Data byte 0x10 to 0x05555 gives erase_req with erase_chip=1.
- R6: Any write whose address or data byte does not match the step expected next sends the tracker back to its start without a request. A new command must then begin again from its first write.
- R7: The boot block is the 8K words whose address bits [19:13] are all zero when BOOT_TOP=0, or all one when BOOT_TOP=1. While bb_lock_n is low, program and sector erase into the boot block are suppressed, and chip erase is suppressed entirely. While bb_lock_n is high, all of these are issued.
- R8: busy is high for exactly OP_CYC clocks, starting the clock after each request. Writes during busy are ignored and do not advance a command.
- R9: dev_clr_n held low for TRP_CYC clocks or more drops any pending command and clears busy. It also gives a one-cycle abort_pulse if an operation was running. The aborted operation is not resumed. A low pulse shorter than TRP_CYC clocks has none of these effects.
- R10: read_ok is low while busy is high and while dev_clr_n is low. After a long clear, read_ok rises exactly TRHR_CYC+2 clocks after dev_clr_n rises.
- R11: After reset all outputs are low. prog_req and erase_req are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel_n | input | 1 | Asynchronous chip select, active low |
| rd_en_n | input | 1 | Asynchronous read enable, active low |
| wr_en_n | input | 1 | Asynchronous write enable, active low |
| bb_lock_n | input | 1 | Boot-block lock, low locks, high unlocks |
| dev_clr_n | input | 1 | Device clear, active low |
| pwr_ok | input | 1 | Supply above lockout level |
| addr_in | input | AW (20) | Word address bus |
| data_in | input | DW (16) | Data bus |
| prog_req | output | 1 | One-cycle program request |
| erase_req | output | 1 | One-cycle erase request |
| erase_chip | output | 1 | With erase_req: 1 chip erase, 0 sector erase |
| req_addr | output | AW (20) | Target address of the request |
| req_data | output | DW (16) | Program data of the request |
| busy | output | 1 | Operation running |
| read_ok | output | 1 | Array reads valid |
| abort_pulse | output | 1 | One-cycle pulse when a running operation is aborted |

## Verification
Directed program and erase sequences are run at addresses on both sides of each boot-block edge, with the lock pin held low and then high. These runs separate the address decode from the lock decision. Two instances, one per boot-block position, share the same stimulus, which separates the bottom decode from the top one. Broken sequences, sub-threshold and long strobes, and blocked strobe combinations are followed by a valid write. This shows whether a rejected cycle wrongly moved the tracker, or a valid one was missed. Clear pulses just under and over the threshold, given both while busy and while idle, separate abort from plain inhibit. A constrained-random series of program commands with random targets, data and lock levels is then checked against a bench-side protection function.

// File: rtl/flash_guard_pkg.sv
`timescale 1ns/1ps
package flash_guard_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_C1, SQ_C2, SQ_PGM, SQ_E3, SQ_E4, SQ_E5
  } seq_t;

  localparam logic [15:0] UNLK_A  = 16'h5555;
  localparam logic [15:0] UNLK_B  = 16'h2AAA;
  localparam logic [7:0]  KEY_A   = 8'hAA;
  localparam logic [7:0]  KEY_B   = 8'h55;
  localparam logic [7:0]  OP_PGM  = 8'hA0;
  localparam logic [7:0]  OP_ERS  = 8'h80;
  localparam logic [7:0]  OP_SECT = 8'h30;
  localparam logic [7:0]  OP_CHIP = 8'h10;
endpackage

// File: rtl/flash_guard_sync.sv
`timescale 1ns/1ps
module flash_guard_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_st
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= RST_VAL;
        else     pipe[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= RST_VAL;
        else     pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/flash_guard_strobe.sv
`timescale 1ns/1ps
module flash_guard_strobe #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int GLITCH_CYC = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          pwr_ok,
  input  logic          pin_low,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          stb,
  output logic [AW-1:0] stb_addr,
  output logic [DW-1:0] stb_data
);
  localparam int CW = $clog2(GLITCH_CYC + 1);

  logic [CW-1:0] cnt;
  logic          fired;
  logic          active;

  // a write needs select and write low, read high, good supply, no clear
  assign active = !ce_n && !we_n && oe_n && pwr_ok && !pin_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      fired    <= 1'b0;
      stb      <= 1'b0;
      stb_addr <= '0;
      stb_data <= '0;
    end else begin
      stb <= 1'b0;
      if (!active) begin
        cnt   <= '0;
        fired <= 1'b0;
      end else if (!fired) begin
        if (cnt == CW'(GLITCH_CYC - 1)) begin
          stb      <= 1'b1;
          fired    <= 1'b1;
          stb_addr <= addr;
          stb_data <= data;
          cnt      <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/flash_guard_seq.sv
`timescale 1ns/1ps
module flash_guard_seq
  import flash_guard_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int BOOT_WORDS = 8192,
  parameter bit BOOT_TOP = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb,
  input  logic [AW-1:0] stb_addr,
  input  logic [DW-1:0] stb_data,
  input  logic          busy,
  input  logic          clr,
  input  logic          wp_n,
  output logic          prog_req,
  output logic          erase_req,
  output logic          erase_chip,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data
);
  localparam int BB = $clog2(BOOT_WORDS);
  localparam int HW = AW - BB;

  seq_t          state;
  logic [HW-1:0] hi;
  logic          in_boot, allow, at_a, at_b;
  logic [7:0]    op;

  assign hi      = stb_addr[AW-1:BB];
  assign in_boot = BOOT_TOP ? (&hi) : (hi == '0);
  assign allow   = wp_n || !in_boot;
  assign at_a    = (stb_addr == AW'(UNLK_A));
  assign at_b    = (stb_addr == AW'(UNLK_B));
  assign op      = stb_data[7:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SQ_IDLE;
      prog_req   <= 1'b0;
      erase_req  <= 1'b0;
      erase_chip <= 1'b0;
      req_addr   <= '0;
      req_data   <= '0;
    end else begin
      prog_req  <= 1'b0;
      erase_req <= 1'b0;
      if (clr) begin
        state <= SQ_IDLE;
      end else if (stb && !busy) begin
        case (state)
          SQ_IDLE: state <= (at_a && op == KEY_A) ? SQ_C1 : SQ_IDLE;
          SQ_C1:   state <= (at_b && op == KEY_B) ? SQ_C2 : SQ_IDLE;
          SQ_C2: begin
            if (at_a && op == OP_PGM)      state <= SQ_PGM;
            else if (at_a && op == OP_ERS) state <= SQ_E3;
            else                           state <= SQ_IDLE;
          end
          SQ_PGM: begin
            state <= SQ_IDLE;
            if (allow) begin
              prog_req   <= 1'b1;
              erase_chip <= 1'b0;
              req_addr   <= stb_addr;
              req_data   <= stb_data;
            end
          end
          SQ_E3: state <= (at_a && op == KEY_A) ? SQ_E4 : SQ_IDLE;
          SQ_E4: state <= (at_b && op == KEY_B) ? SQ_E5 : SQ_IDLE;
          SQ_E5: begin
            state <= SQ_IDLE;
            if (op == OP_SECT && allow) begin
              erase_req  <= 1'b1;
              erase_chip <= 1'b0;
              req_addr   <= stb_addr;
              req_data   <= stb_data;
            end else if (at_a && op == OP_CHIP && wp_n) begin
              erase_req  <= 1'b1;
              erase_chip <= 1'b1;
              req_addr   <= stb_addr;
              req_data   <= stb_data;
            end
          end
          default: state <= SQ_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_guard_ctl.sv
`timescale 1ns/1ps
module flash_guard_ctl #(
  parameter int TRP_CYC = 8,
  parameter int TRHR_CYC = 5,
  parameter int OP_CYC = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic pin_low,
  output logic busy,
  output logic read_ok,
  output logic abort_pulse,
  output logic in_reset
);
  localparam int LW = $clog2(TRP_CYC + 1);
  localparam int RW = $clog2(TRHR_CYC + 1);
  localparam int BW = $clog2(OP_CYC + 1);

  logic [LW-1:0] low_cnt, low_nxt;
  logic [RW-1:0] rec_cnt, rec_nxt;
  logic [BW-1:0] bsy_cnt, bsy_nxt;
  logic          long_hit, released;

  assign long_hit = pin_low && (low_cnt == LW'(TRP_CYC - 1));
  assign released = !pin_low && (low_cnt == LW'(TRP_CYC));
  assign in_reset = (low_cnt == LW'(TRP_CYC));

  always_comb begin
    if (!pin_low)                        low_nxt = '0;
    else if (low_cnt != LW'(TRP_CYC))    low_nxt = low_cnt + LW'(1);
    else                                 low_nxt = low_cnt;

    if (released)                        rec_nxt = RW'(TRHR_CYC);
    else if (rec_cnt != '0)              rec_nxt = rec_cnt - RW'(1);
    else                                 rec_nxt = '0;

    if (long_hit)                        bsy_nxt = '0;
    else if (req)                        bsy_nxt = BW'(OP_CYC);
    else if (bsy_cnt != '0)              bsy_nxt = bsy_cnt - BW'(1);
    else                                 bsy_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt     <= '0;
      rec_cnt     <= '0;
      bsy_cnt     <= '0;
      busy        <= 1'b0;
      read_ok     <= 1'b0;
      abort_pulse <= 1'b0;
    end else begin
      low_cnt     <= low_nxt;
      rec_cnt     <= rec_nxt;
      bsy_cnt     <= bsy_nxt;
      busy        <= (bsy_nxt != '0);
      read_ok     <= !pin_low && (rec_nxt == '0) && (bsy_nxt == '0);
      abort_pulse <= long_hit && (bsy_cnt != '0);
    end
  end
endmodule

// File: rtl/flash_guard.sv
`timescale 1ns/1ps
module flash_guard #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int GLITCH_CYC = 3,
  parameter int BOOT_WORDS = 8192,
  parameter bit BOOT_TOP = 1'b0,
  parameter int TRP_CYC = 8,
  parameter int TRHR_CYC = 5,
  parameter int OP_CYC = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chip_sel_n,
  input  logic          rd_en_n,
  input  logic          wr_en_n,
  input  logic          bb_lock_n,
  input  logic          dev_clr_n,
  input  logic          pwr_ok,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          prog_req,
  output logic          erase_req,
  output logic          erase_chip,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data,
  output logic          busy,
  output logic          read_ok,
  output logic          abort_pulse
);
  localparam int CTL_W = 6;
  localparam int BUS_W = AW + DW;

  logic [CTL_W-1:0] ctl_s;
  logic [BUS_W-1:0] bus_s;
  logic ce_s, oe_s, we_s, wp_s, clr_s, pwr_s, pin_low;
  logic stb, in_reset;
  logic [AW-1:0] stb_addr;
  logic [DW-1:0] stb_data;

  flash_guard_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync_ctl (
    .clk(clk), .rst(rst),
    .d({chip_sel_n, rd_en_n, wr_en_n, bb_lock_n, dev_clr_n, pwr_ok}),
    .q(ctl_s)
  );

  flash_guard_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
    .clk(clk), .rst(rst), .d({addr_in, data_in}), .q(bus_s)
  );

  assign {ce_s, oe_s, we_s, wp_s, clr_s, pwr_s} = ctl_s;
  assign pin_low = !clr_s;

  flash_guard_strobe #(.AW(AW), .DW(DW), .GLITCH_CYC(GLITCH_CYC)) u_strobe (
    .clk(clk), .rst(rst),
    .ce_n(ce_s), .oe_n(oe_s), .we_n(we_s), .pwr_ok(pwr_s), .pin_low(pin_low),
    .addr(bus_s[BUS_W-1:DW]), .data(bus_s[DW-1:0]),
    .stb(stb), .stb_addr(stb_addr), .stb_data(stb_data)
  );

  flash_guard_seq #(.AW(AW), .DW(DW), .BOOT_WORDS(BOOT_WORDS), .BOOT_TOP(BOOT_TOP)) u_seq (
    .clk(clk), .rst(rst),
    .stb(stb), .stb_addr(stb_addr), .stb_data(stb_data),
    .busy(busy), .clr(in_reset), .wp_n(wp_s),
    .prog_req(prog_req), .erase_req(erase_req), .erase_chip(erase_chip),
    .req_addr(req_addr), .req_data(req_data)
  );

  flash_guard_ctl #(.TRP_CYC(TRP_CYC), .TRHR_CYC(TRHR_CYC), .OP_CYC(OP_CYC)) u_ctl (
    .clk(clk), .rst(rst),
    .req(prog_req || erase_req), .pin_low(pin_low),
    .busy(busy), .read_ok(read_ok), .abort_pulse(abort_pulse), .in_reset(in_reset)
  );
endmodule

// File: rtl/flash_guard_chk.sv
`timescale 1ns/1ps
module flash_guard_chk #(
  parameter int AW = 20,
  parameter int BOOT_WORDS = 8192,
  parameter bit BOOT_TOP = 1'b0
) (
  input logic          clk,
  input logic          rst,
  input logic          prog_req,
  input logic          erase_req,
  input logic          erase_chip,
  input logic [AW-1:0] req_addr,
  input logic          busy,
  input logic          read_ok,
  input logic          abort_pulse,
  input logic          wp_s
);
  localparam int BB = $clog2(BOOT_WORDS);

  logic boot_hit;
  assign boot_hit = BOOT_TOP ? (&req_addr[AW-1:BB]) : (req_addr[AW-1:BB] == '0);

  assert_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(prog_req && erase_req));

  assert_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    (prog_req || erase_req) |=> !(prog_req || erase_req));

  assert_busy_after_req_R8: assert property (@(posedge clk) disable iff (rst)
    (prog_req || erase_req) |=> busy);

  assert_boot_lock_R7: assert property (@(posedge clk) disable iff (rst)
    ((prog_req || (erase_req && !erase_chip)) && boot_hit) |-> $past(wp_s));

  assert_chip_lock_R7: assert property (@(posedge clk) disable iff (rst)
    (erase_req && erase_chip) |-> $past(wp_s));

  assert_abort_clears_R9: assert property (@(posedge clk) disable iff (rst)
    abort_pulse |-> !busy);

  assert_read_block_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !read_ok);
endmodule

bind flash_guard flash_guard_chk #(.AW(AW), .BOOT_WORDS(BOOT_WORDS), .BOOT_TOP(BOOT_TOP)) u_chk (
  .clk(clk), .rst(rst), .prog_req(prog_req), .erase_req(erase_req),
  .erase_chip(erase_chip), .req_addr(req_addr), .busy(busy), .read_ok(read_ok),
  .abort_pulse(abort_pulse), .wp_s(wp_s)
);

// File: tb/sim_flash_guard.sv
`timescale 1ns/1ps
module sim_flash_guard;
  localparam int GL = 3, TRP = 8, TRHR = 5, OPC = 40;

  logic clk = 1'b0, rst = 1'b1;
  logic chip_sel_n = 1'b1, rd_en_n = 1'b1, wr_en_n = 1'b1;
  logic bb_lock_n = 1'b1, dev_clr_n = 1'b1, pwr_ok = 1'b1;
  logic [19:0] addr_in = '0;
  logic [15:0] data_in = '0;
  logic p0, e0, ec0, b0, ok0, ab0, p1, e1, ec1, b1, ok1, ab1;
  logic [19:0] ra0, ra1;
  logic [15:0] rd0, rd1;

  int checks = 0, fails = 0;
  int np0 = 0, ne0 = 0, np1 = 0, nab0 = 0, bcyc0 = 0;
  logic [19:0] la0;
  logic [15:0] ld0;
  logic lc0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_guard #(.GLITCH_CYC(GL), .BOOT_TOP(1'b0), .TRP_CYC(TRP), .TRHR_CYC(TRHR), .OP_CYC(OPC)) u0 (
    .clk(clk), .rst(rst), .chip_sel_n(chip_sel_n), .rd_en_n(rd_en_n), .wr_en_n(wr_en_n),
    .bb_lock_n(bb_lock_n), .dev_clr_n(dev_clr_n), .pwr_ok(pwr_ok), .addr_in(addr_in),
    .data_in(data_in), .prog_req(p0), .erase_req(e0), .erase_chip(ec0), .req_addr(ra0),
    .req_data(rd0), .busy(b0), .read_ok(ok0), .abort_pulse(ab0));

  flash_guard #(.GLITCH_CYC(GL), .BOOT_TOP(1'b1), .TRP_CYC(TRP), .TRHR_CYC(TRHR), .OP_CYC(OPC)) u1 (
    .clk(clk), .rst(rst), .chip_sel_n(chip_sel_n), .rd_en_n(rd_en_n), .wr_en_n(wr_en_n),
    .bb_lock_n(bb_lock_n), .dev_clr_n(dev_clr_n), .pwr_ok(pwr_ok), .addr_in(addr_in),
    .data_in(data_in), .prog_req(p1), .erase_req(e1), .erase_chip(ec1), .req_addr(ra1),
    .req_data(rd1), .busy(b1), .read_ok(ok1), .abort_pulse(ab1));

  always @(negedge clk) if (!rst) begin
    if (p0) begin np0++; la0 = ra0; ld0 = rd0; end
    if (e0) begin ne0++; la0 = ra0; lc0 = ec0; end
    if (p1) np1++;
    if (ab0) nab0++;
    if (b0) bcyc0++;
  end

  function automatic bit allowed(input logic [19:0] a, input bit top, input bit wp);
    return wp || !(top ? (a[19:13] == 7'h7F) : (a[19:13] == 7'h00));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [15:0] d, input int len = GL);
    @(negedge clk);
    addr_in = a; data_in = d; chip_sel_n = 0; wr_en_n = 0; rd_en_n = 1;
    repeat (len) @(negedge clk);
    chip_sel_n = 1; wr_en_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_raw(input logic [19:0] a, input logic [15:0] d,
                        input logic ce, input logic oe, input logic we);
    @(negedge clk);
    addr_in = a; data_in = d; chip_sel_n = ce; rd_en_n = oe; wr_en_n = we;
    repeat (GL + 2) @(negedge clk);
    chip_sel_n = 1; rd_en_n = 1; wr_en_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic unlock3(input logic [7:0] op);
    wr(20'h05555, 16'h00AA); wr(20'h02AAA, 16'h0055); wr(20'h05555, {8'h00, op});
  endtask

  task automatic prog(input logic [19:0] a, input logic [15:0] d);
    unlock3(8'hA0); wr(a, d);
  endtask

  task automatic erase(input logic [19:0] a, input logic [7:0] op);
    unlock3(8'h80); wr(20'h05555, 16'h00AA); wr(20'h02AAA, 16'h0055); wr(a, {8'h00, op});
  endtask

  task automatic settle();
    while (b0 || b1) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_wp(input logic v);
    @(negedge clk); bb_lock_n = v; repeat (3) @(negedge clk);
  endtask

  task automatic clr_pulse(input int len);
    @(negedge clk); dev_clr_n = 0;
    repeat (len) @(negedge clk);
    dev_clr_n = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int n0, n1, n, k;
    logic [19:0] a;
    logic [15:0] d;
    bit wp, x0, x1;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(!p0 && !e0 && !b0 && !ab0, "R11 reset outputs", {p0, e0, b0, ab0}, 0);
    chk(ok0 == 1, "R10 read_ok after reset", ok0, 1);

    // R4 program outside boot, lock low; R8 busy length
    set_wp(0);
    bcyc0 = 0;
    prog(20'h12345, 16'hBEEF);
    chk(np0 == 1, "R4 prog count", np0, 1);
    chk(la0 == 20'h12345 && ld0 == 16'hBEEF, "R4 prog addr/data", la0, 20'h12345);
    settle();
    chk(bcyc0 == OPC, "R8 busy length", bcyc0, OPC);

    // R7 bottom edge
    n0 = np0; n1 = np1;
    prog(20'h01FFF, 16'h1111); settle();
    chk(np0 == n0, "R7 bottom boot locked", np0 - n0, 0);
    chk(np1 == n1 + 1, "R7 top variant allows 0x01FFF", np1 - n1, 1);
    n0 = np0;
    prog(20'h02000, 16'h2222); settle();
    chk(np0 == n0 + 1 && la0 == 20'h02000, "R7 first word above boot", la0, 20'h02000);
    n0 = np0; n1 = np1;
    prog(20'hFE000, 16'h3333); settle();
    chk(np0 == n0 + 1, "R7 bottom variant allows 0xFE000", np0 - n0, 1);
    chk(np1 == n1, "R7 top boot locked", np1 - n1, 0);
    n1 = np1;
    prog(20'hFDFFF, 16'h3434); settle();
    chk(np1 == n1 + 1, "R7 top variant below boot", np1 - n1, 1);
    set_wp(1);
    n0 = np0;
    prog(20'h00000, 16'h4444); settle();
    chk(np0 == n0 + 1 && ld0 == 16'h4444, "R7 unlocked boot write", ld0, 16'h4444);

    // R5 erase forms
    set_wp(0);
    n = ne0;
    erase(20'h03000, 8'h30); settle();
    chk(ne0 == n + 1 && lc0 == 0 && la0 == 20'h03000, "R5 sector erase", la0, 20'h03000);
    n = ne0;
    erase(20'h00100, 8'h30); settle();
    chk(ne0 == n, "R7 sector erase in boot locked", ne0 - n, 0);
    n = ne0;
    erase(20'h05555, 8'h10); settle();
    chk(ne0 == n, "R7 chip erase locked", ne0 - n, 0);
    set_wp(1);
    n = ne0;
    erase(20'h05555, 8'h10); settle();
    chk(ne0 == n + 1 && lc0 == 1, "R5 chip erase", lc0, 1);
    chk(np0 == n0 + 1, "R11 erase gives no prog", np0, n0 + 1);

    // R6 mismatch
    n0 = np0;
    wr(20'h05555, 16'h00AA); wr(20'h02AAA, 16'h0055); wr(20'h05555, 16'h0077);
    wr(20'h05555, 16'h00A0); wr(20'h04000, 16'h5555); settle();
    chk(np0 == n0, "R6 broken sequence", np0 - n0, 0);
    wr(20'h05555, 16'h00AA); wr(20'h02AAB, 16'h0055); wr(20'h05555, 16'h00A0);
    wr(20'h04001, 16'h5555); settle();
    chk(np0 == n0, "R6 wrong address", np0 - n0, 0);

    // R2 glitch rejection
    wr(20'h05555, 16'h00AA, GL - 1); wr(20'h02AAA, 16'h0055); wr(20'h05555, 16'h00A0);
    wr(20'h04002, 16'h6666); settle();
    chk(np0 == n0, "R2 short strobe dropped", np0 - n0, 0);
    wr(20'h05555, 16'h00AA, GL + 5); wr(20'h02AAA, 16'h0055, GL + 5);
    wr(20'h05555, 16'h00A0, GL + 5); wr(20'h04003, 16'h6767, GL + 5); settle();
    chk(np0 == n0 + 1 && la0 == 20'h04003, "R2 long strobe once", np0 - n0, 1);

    // R1 strobe combinations
    n0 = np0;
    unlock3(8'hA0);
    wr_raw(20'h04100, 16'h1, 0, 0, 0);
    wr_raw(20'h04101, 16'h2, 1, 1, 0);
    wr_raw(20'h04102, 16'h3, 0, 1, 1);
    chk(np0 == n0, "R1 blocked combinations", np0 - n0, 0);
    wr(20'h04103, 16'h7777); settle();
    chk(np0 == n0 + 1 && la0 == 20'h04103, "R1 slot kept", la0, 20'h04103);

    // R3 supply lockout
    n0 = np0;
    unlock3(8'hA0);
    @(negedge clk); pwr_ok = 0;
    wr(20'h04200, 16'h8888);
    @(negedge clk); pwr_ok = 1;
    chk(np0 == n0, "R3 low supply blocks", np0 - n0, 0);
    wr(20'h04201, 16'h8989); settle();
    chk(np0 == n0 + 1 && la0 == 20'h04201, "R3 slot kept", la0, 20'h04201);

    // R8 writes ignored while busy
    n0 = np0;
    prog(20'h04300, 16'h9999);
    prog(20'h04301, 16'h9A9A);
    chk(b0 == 1, "R8 still busy", b0, 1);
    settle();
    chk(np0 == n0 + 1 && la0 == 20'h04300, "R8 sequence during busy ignored", np0 - n0, 1);
    wr(20'h04302, 16'h9B9B); settle();
    chk(np0 == n0 + 1, "R8 tracker idle after busy", np0 - n0, 1);

    // R9 / R10 clear handling
    n0 = np0; n = nab0;
    prog(20'h04400, 16'hAAAA);
    clr_pulse(TRP - 1);
    repeat (4) @(negedge clk);
    chk(nab0 == n && b0 == 1, "R9 short clear no abort", nab0 - n, 0);
    clr_pulse(TRP + 2);
    k = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (ok0) break;
      k++;
    end
    chk(nab0 == n + 1, "R9 abort pulse", nab0 - n, 1);
    chk(b0 == 0, "R9 busy cleared", b0, 0);
    chk(k == TRHR + 2, "R10 recovery after abort", k, TRHR + 2);
    repeat (4) @(negedge clk);
    chk(np0 == n0 + 1 && b0 == 0, "R9 not resumed", b0, 0);
    settle();
    n = nab0;
    unlock3(8'hA0);
    clr_pulse(TRP);
    k = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (ok0) break;
      k++;
    end
    chk(k == TRHR + 2, "R10 recovery when idle", k, TRHR + 2);
    chk(nab0 == n, "R9 no abort when idle", nab0 - n, 0);
    n0 = np0;
    wr(20'h04500, 16'hBBBB); settle();
    chk(np0 == n0, "R9 clear drops pending command", np0 - n0, 0);

    // R4 R7 constrained random program commands
    for (int it = 0; it < 30; it++) begin
      wp = 1'($urandom_range(0, 1));
      case ($urandom_range(0, 2))
        0: a = {7'h00, 13'($urandom)};
        1: a = {7'h7F, 13'($urandom)};
        default: a = 20'($urandom);
      endcase
      d = 16'($urandom);
      set_wp(wp);
      n0 = np0; n1 = np1;
      x0 = allowed(a, 1'b0, wp);
      x1 = allowed(a, 1'b1, wp);
      prog(a, d);
      chk(np0 - n0 == int'(x0), "R7 random bottom decision", np0 - n0, int'(x0));
      chk(np1 - n1 == int'(x1), "R7 random top decision", np1 - n1, int'(x1));
      if (x0) chk(la0 == a && ld0 == d, "R4 random target", la0, a);
      settle();
    end

    finish_run();
  end
endmodule